// File: doc/BRIEF.md
# Acquisition Result FIFO with Error Flags

This block sits between a sampling engine and a host bus and buffers conversion results. Each 12-bit conversion word comes in with a valid strobe and a polarity flag for its channel. The block keeps the word in a first-in first-out store of 512 entries, so the host has up to 512 sample intervals of slack before data is lost. On the host side, a word is presented as a 16-bit value. Results from bipolar channels are sign-extended two's complement. Results from unipolar channels are zero-extended straight binary.

While a sequence runs, two error conditions are watched. A conversion arriving into a full store is an overflow. A new conversion start while the converter still reports busy is an overrun. Either error is sticky: it halts acquisition and ends the sequence. The sequence also ends normally on an end-of-sequence strobe. The completion flag is reported as clean only when neither error flag is set.

A service request output can drive a DMA engine or an interrupt line, in one of two modes:
- Per-transfer mode: the request is raised whenever the store holds data.
- Drain mode: the request rises at half full and is held until the store is empty.

A separate completion interrupt follows the completion flag when enabled. A single clear strobe ends any sequence, empties the store and drops every flag and pending interrupt.

Top module: `acq_result_fifo`

## Requirements
- R1: After reset, empty_o=1, and half_o, ovf_o, ovr_o, done_o, done_ok_o, acq_active_o, svc_req_o and irq_o are all 0.
- R2: While acq_active_o=1, each cycle with cnv_valid_i=1 stores one word. Words are read back in arrival order. rd_data_o shows the oldest word, and rd_i=1 removes it at the clock edge. The store holds 512 words.
- R3: A word stored with cnv_bipolar_i=1 reads out with bits 15..12 equal to bit 11 of the code. A word stored with cnv_bipolar_i=0 reads out with bits 15..12 equal to 0. In both cases bits 11..0 equal the code.
- R4: empty_o=1 exactly when no word is stored. rd_i while empty removes nothing: a word written afterwards is the next one read.
- R5: half_o=1 exactly when at least 256 words are stored.
- R6: A conversion that arrives while 512 words are stored and rd_i=0 is dropped. From the next cycle, ovf_o=1 and acq_active_o=0. ovf_o stays set until clear.
- R7: A conversion and a read in the same cycle on a full store behave as a read followed by a write. No overflow is flagged, and the new word is appended.
- R8: conv_start_i=1 together with conv_busy_i=1 while acq_active_o=1 sets ovr_o from the next cycle and drops acq_active_o. ovr_o stays set until clear.
- R9: end_i=1 while active, an overflow or an overrun ends the sequence by setting done_o. done_ok_o=1 only when done_o=1 and neither ovf_o nor ovr_o is set. Conversions after the end are not stored.
- R10: clr_i=1 makes the next cycle show empty_o=1 with ovf_o, ovr_o, done_o, acq_active_o and irq_o all 0.
- R11: With req_drain_i=0, svc_req_o equals not empty_o. With req_drain_i=1, svc_req_o rises when half_o rises and stays high until empty_o=1.
- R12: irq_o=1 exactly when done_o=1 and irq_en_i=1.
- R13: start_i=1 sets acq_active_o from the next cycle, unless ovf_o or ovr_o is set; in that case start_i is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | Clear strobe: stop, empty, drop flags |
| start_i | input | 1 | Begin an acquisition sequence |
| end_i | input | 1 | End-of-sequence strobe |
| conv_start_i | input | 1 | Converter start pulse |
| conv_busy_i | input | 1 | Converter busy flag |
| cnv_valid_i | input | 1 | Conversion result valid |
| cnv_code_i | input | 12 | Conversion code |
| cnv_bipolar_i | input | 1 | Channel polarity of this result (1 = bipolar) |
| rd_i | input | 1 | Host read: pop the oldest word |
| req_drain_i | input | 1 | Service request mode (1 = drain from half full to empty) |
| irq_en_i | input | 1 | Completion interrupt enable |
| rd_data_o | output | 16 | Formatted oldest word |
| empty_o | output | 1 | No word stored |
| half_o | output | 1 | At least half the store filled |
| ovf_o | output | 1 | Sticky overflow |
| ovr_o | output | 1 | Sticky overrun |
| done_o | output | 1 | Sequence ended |
| done_ok_o | output | 1 | Sequence ended without error |
| acq_active_o | output | 1 | Conversions are being accepted |
| svc_req_o | output | 1 | Service request for DMA or interrupt |
| irq_o | output | 1 | Completion interrupt |

## Verification
Several properties are checked on every cycle:
- a clear leaves the block empty and idle;
- both error flags and the completion flag stay sticky;
- an error flag always coincides with a halted sequence;
- half full implies not empty;
- no service request is raised on an empty store;
- the upper bits of any word shown are a valid extension.

Other behaviours can only be shown by the bench's scenarios:
- data order across a full 512-word round;
- the loss of exactly the overflowing word;
- read-before-write on a full store;
- the per-channel choice between sign and zero extension;
- the hold of the drain-mode request from half full down to empty.

// File: rtl/acqf_pkg.sv
package acqf_pkg;
    localparam int CONV_W = 12;
    localparam int WORD_W = 16;
    localparam int EXT_W  = WORD_W - CONV_W;

    typedef struct packed {
        logic              bip;
        logic [CONV_W-1:0] code;
    } sample_t;

    localparam int SAMPLE_W = $bits(sample_t);

    function automatic logic [WORD_W-1:0] fmt_word(sample_t s);
        if (s.bip)
            return {{EXT_W{s.code[CONV_W-1]}}, s.code};
        else
            return {{EXT_W{1'b0}}, s.code};
    endfunction
endpackage

// File: rtl/acqf_store.sv
module acqf_store
    import acqf_pkg::*;
#(
    parameter int DEPTH = 512,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  sample_t       wdata,
    input  logic          pop,
    output sample_t       head,
    output logic [CW-1:0] count
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    sample_t       mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push)
            mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head = mem[rd_ptr];
endmodule

// File: rtl/acqf_ctrl.sv
module acqf_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic start,
    input  logic seq_end,
    input  logic conv_start,
    input  logic conv_busy,
    input  logic cnv_valid,
    input  logic full,
    input  logic pop,
    output logic push,
    output logic active,
    output logic ovf,
    output logic ovr,
    output logic done
);
    logic ovf_evt;
    logic ovr_evt;
    logic start_ok;

    always_comb begin
        ovf_evt  = active && cnv_valid && full && !pop;
        ovr_evt  = active && conv_start && conv_busy;
        push     = active && cnv_valid && (!full || pop);
        start_ok = start && !ovf && !ovr;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            active <= 1'b0;
            ovf    <= 1'b0;
            ovr    <= 1'b0;
            done   <= 1'b0;
        end else begin
            if (start_ok) begin
                active <= 1'b1;
                done   <= 1'b0;
            end
            if (active && seq_end) begin
                active <= 1'b0;
                done   <= 1'b1;
            end
            if (ovf_evt) begin
                ovf    <= 1'b1;
                active <= 1'b0;
                done   <= 1'b1;
            end
            if (ovr_evt) begin
                ovr    <= 1'b1;
                active <= 1'b0;
                done   <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/acqf_req.sv
module acqf_req (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic drain_mode,
    input  logic empty,
    input  logic half,
    output logic req
);
    logic hold_q;

    always_ff @(posedge clk) begin
        if (rst || clr)
            hold_q <= 1'b0;
        else if (half)
            hold_q <= 1'b1;
        else if (empty)
            hold_q <= 1'b0;
    end

    always_comb begin
        if (drain_mode)
            req = half || (hold_q && !empty);
        else
            req = !empty;
    end
endmodule

// File: rtl/acq_result_fifo.sv
module acq_result_fifo
    import acqf_pkg::*;
#(
    parameter int DEPTH = 512,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1,
    localparam int HALF = DEPTH / 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_i,
    input  logic              start_i,
    input  logic              end_i,
    input  logic              conv_start_i,
    input  logic              conv_busy_i,
    input  logic              cnv_valid_i,
    input  logic [CONV_W-1:0] cnv_code_i,
    input  logic              cnv_bipolar_i,
    input  logic              rd_i,
    input  logic              req_drain_i,
    input  logic              irq_en_i,
    output logic [WORD_W-1:0] rd_data_o,
    output logic              empty_o,
    output logic              half_o,
    output logic              ovf_o,
    output logic              ovr_o,
    output logic              done_o,
    output logic              done_ok_o,
    output logic              acq_active_o,
    output logic              svc_req_o,
    output logic              irq_o
);
    sample_t       wdata;
    sample_t       head;
    logic [CW-1:0] count;
    logic          push;
    logic          pop;
    logic          full;

    assign wdata.bip  = cnv_bipolar_i;
    assign wdata.code = cnv_code_i;

    assign empty_o = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign half_o  = (count >= CW'(HALF));
    assign pop     = rd_i && !empty_o && !clr_i;

    acqf_store #(.DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst   (rst),
        .flush (clr_i),
        .push  (push),
        .wdata (wdata),
        .pop   (pop),
        .head  (head),
        .count (count)
    );

    acqf_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr_i),
        .start      (start_i),
        .seq_end    (end_i),
        .conv_start (conv_start_i),
        .conv_busy  (conv_busy_i),
        .cnv_valid  (cnv_valid_i && !clr_i),
        .full       (full),
        .pop        (pop),
        .push       (push),
        .active     (acq_active_o),
        .ovf        (ovf_o),
        .ovr        (ovr_o),
        .done       (done_o)
    );

    acqf_req u_req (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr_i),
        .drain_mode (req_drain_i),
        .empty      (empty_o),
        .half       (half_o),
        .req        (svc_req_o)
    );

    assign rd_data_o = fmt_word(head);
    assign done_ok_o = done_o && !ovf_o && !ovr_o;
    assign irq_o     = done_o && irq_en_i;
endmodule

// File: rtl/acqf_checker.sv
module acqf_checker (
    input logic        clk,
    input logic        rst,
    input logic        clr_i,
    input logic        acq_active_o,
    input logic        empty_o,
    input logic        half_o,
    input logic        ovf_o,
    input logic        ovr_o,
    input logic        done_o,
    input logic        svc_req_o,
    input logic [15:0] rd_data_o
);
    AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (empty_o && !ovf_o && !ovr_o && !done_o && !acq_active_o)); // R10
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovf_o && !clr_i) |=> ovf_o); // R6
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovr_o && !clr_i) |=> ovr_o); // R8
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (done_o && !clr_i && !acq_active_o) |=> (done_o || acq_active_o)); // R9
    AST_ERR_HALTS: assert property (@(posedge clk) disable iff (rst)
        (ovf_o || ovr_o) |-> !acq_active_o); // R13
    AST_HALF_NOT_EMPTY: assert property (@(posedge clk) disable iff (rst)
        half_o |-> !empty_o); // R5
    AST_NO_REQ_EMPTY: assert property (@(posedge clk) disable iff (rst)
        empty_o |-> !svc_req_o); // R11
    AST_EXT_VALID: assert property (@(posedge clk) disable iff (rst)
        !empty_o |-> (rd_data_o[15:12] == {4{rd_data_o[11]}} || rd_data_o[15:12] == 4'h0)); // R3
endmodule

bind acq_result_fifo acqf_checker u_acqf_checker (
    .clk          (clk),
    .rst          (rst),
    .clr_i        (clr_i),
    .acq_active_o (acq_active_o),
    .empty_o      (empty_o),
    .half_o       (half_o),
    .ovf_o        (ovf_o),
    .ovr_o        (ovr_o),
    .done_o       (done_o),
    .svc_req_o    (svc_req_o),
    .rd_data_o    (rd_data_o)
);

// File: tb/tb_acq_result_fifo.sv
`timescale 1ns/1ps
module tb_acq_result_fifo;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clr_i = 0, start_i = 0, end_i = 0, conv_start_i = 0, conv_busy_i = 0;
    logic        cnv_valid_i = 0, cnv_bipolar_i = 0, rd_i = 0, req_drain_i = 0, irq_en_i = 0;
    logic [11:0] cnv_code_i = '0;
    logic [15:0] rd_data_o;
    logic        empty_o, half_o, ovf_o, ovr_o, done_o, done_ok_o, acq_active_o, svc_req_o, irq_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    acq_result_fifo dut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic push(input logic [11:0] code, input logic bip);
        cnv_valid_i = 1; cnv_code_i = code; cnv_bipolar_i = bip;
        cyc();
        cnv_valid_i = 0;
    endtask

    task automatic pop();
        rd_i = 1;
        cyc();
        rd_i = 0;
    endtask

    task automatic clear_start();
        clr_i = 1; cyc(); clr_i = 0;
        start_i = 1; cyc(); start_i = 0;
    endtask

    task automatic t_reset();
        chk("R1 empty", empty_o, 1);
        chk("R1 flags", {half_o, ovf_o, ovr_o, done_o, done_ok_o, acq_active_o, svc_req_o, irq_o}, 0);
    endtask

    task automatic t_order_format();
        clear_start();
        chk("R13 start", acq_active_o, 1);
        push(12'h800, 1); push(12'hFFF, 0); push(12'h7FF, 1); push(12'h123, 0);
        chk("R3 bipolar negative", rd_data_o, 16'hF800); pop();
        chk("R3 unipolar full scale", rd_data_o, 16'h0FFF); pop();
        chk("R3 bipolar positive", rd_data_o, 16'h07FF); pop();
        chk("R2 order", rd_data_o, 16'h0123); pop();
        chk("R4 empty after drain", empty_o, 1);
    endtask

    task automatic t_empty_read();
        clear_start();
        pop(); pop();
        chk("R4 still empty", empty_o, 1);
        push(12'h3C3, 0);
        chk("R4 not empty", empty_o, 0);
        chk("R4 no phantom pop", rd_data_o, 16'h03C3);
    endtask

    task automatic t_fill_overflow();
        int bad = 0;
        clear_start();
        for (int i = 0; i < 255; i++) push(12'(i), 0);
        chk("R5 below half", half_o, 0);
        push(12'd255, 0);
        chk("R5 at half", half_o, 1);
        for (int i = 256; i < 512; i++) push(12'(i), 0);
        chk("R6 full no ovf", ovf_o, 0);
        chk("R6 still active", acq_active_o, 1);
        push(12'hABC, 0);
        chk("R6 ovf set", ovf_o, 1);
        chk("R6 halted", acq_active_o, 0);
        chk("R9 done on error", done_o, 1);
        chk("R9 not clean", done_ok_o, 0);
        cyc();
        chk("R6 sticky", ovf_o, 1);
        for (int i = 0; i < 512; i++) begin
            if (rd_data_o !== 16'(i)) bad++;
            pop();
        end
        chk("R2 512 in order", bad, 0);
        chk("R6 dropped word absent", empty_o, 1);
    endtask

    task automatic t_full_rdwr();
        clear_start();
        for (int i = 0; i < 512; i++) push(12'(i), 0);
        cnv_valid_i = 1; cnv_code_i = 12'h5A5; cnv_bipolar_i = 0; rd_i = 1;
        cyc();
        cnv_valid_i = 0; rd_i = 0;
        chk("R7 no ovf", ovf_o, 0);
        chk("R7 still active", acq_active_o, 1);
        chk("R7 head advanced", rd_data_o, 16'h0001);
        for (int i = 0; i < 511; i++) pop();
        chk("R7 appended word", rd_data_o, 16'h05A5);
        pop();
        chk("R7 drained", empty_o, 1);
    endtask

    task automatic t_overrun();
        clear_start();
        conv_start_i = 1; conv_busy_i = 1; cyc(); conv_start_i = 0; conv_busy_i = 0;
        chk("R8 ovr set", ovr_o, 1);
        chk("R8 halted", acq_active_o, 0);
        chk("R9 done not clean", {done_o, done_ok_o}, 2'b10);
        start_i = 1; cyc(); start_i = 0;
        chk("R13 start ignored", acq_active_o, 0);
        irq_en_i = 1; cyc();
        chk("R12 irq", irq_o, 1);
        clr_i = 1; cyc(); clr_i = 0;
        chk("R10 clear", {ovr_o, ovf_o, done_o, acq_active_o, irq_o, empty_o}, 6'b000001);
        irq_en_i = 0;
        start_i = 1; cyc(); start_i = 0;
        chk("R13 start after clear", acq_active_o, 1);
    endtask

    task automatic t_complete();
        clear_start();
        push(12'h010, 0);
        end_i = 1; cyc(); end_i = 0;
        chk("R9 done clean", {done_o, done_ok_o, acq_active_o}, 3'b110);
        chk("R12 irq disabled", irq_o, 0);
        irq_en_i = 1; #1;
        chk("R12 irq enabled", irq_o, 1);
        push(12'h020, 0);
        pop();
        chk("R9 post-end word not stored", empty_o, 1);
        clr_i = 1; cyc(); clr_i = 0;
        chk("R10 irq cancelled", irq_o, 0);
        irq_en_i = 0;
    endtask

    task automatic t_req_modes();
        clear_start();
        req_drain_i = 0;
        push(12'h001, 0);
        chk("R11 per-transfer req", svc_req_o, 1);
        pop();
        chk("R11 per-transfer idle", svc_req_o, 0);
        req_drain_i = 1;
        push(12'h001, 0);
        chk("R11 drain below half", svc_req_o, 0);
        for (int i = 0; i < 255; i++) push(12'h002, 0);
        chk("R11 drain at half", svc_req_o, 1);
        for (int i = 0; i < 255; i++) pop();
        chk("R11 drain held", {svc_req_o, half_o}, 2'b10);
        pop();
        chk("R11 drain released", svc_req_o, 0);
        req_drain_i = 0;
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        cyc(); cyc();
        rst = 0;
        cyc();
        t_reset();
        t_order_format();
        t_empty_read();
        t_fill_overflow();
        t_full_rdwr();
        t_overrun();
        t_complete();
        t_req_modes();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule